// File: doc/BRIEF.md
# Single-Flag Carry, Borrow and Overflow Arithmetic Unit

This block performs the arithmetic steps that rely on a single status bit, called T, which is carried from one instruction to the next. Depending on the operation, T serves as the carry-in and carry-out of a multi-word add, as the borrow of a multi-word subtract or negate, as a signed-overflow flag, or as the extra bit in a 33-bit rotate. The unit takes a source operand A, a destination operand B, a 3-bit operation code and the current T. From these it computes a result word and the next T value, with no clock cycle between input and output.

The next T value is also captured in a flag register. That register loads only on a cycle where the valid strobe is high, and it resets to 0. A write strobe output goes high in the cycle after each load, so that downstream logic can see that the registered flag has just been written. Plain add, subtract and logic operations are handled elsewhere in the datapath, and so are instruction decode and register storage.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add with carry): result = B + A + T modulo 2^32. The new T is 1 when B + A carries out of bit 31, or when adding T to that sum carries out of bit 31.
- R2: Code 2 (subtract with borrow): result = B - A - T modulo 2^32. The new T is 1 when B - A borrows, or when subtracting T from that difference borrows.
- R3: Code 4 (negate with borrow): result = 0 - A - T modulo 2^32. The new T is 1 when 0 - A is nonzero, or when subtracting T from it borrows. B is not used.
- R4: Code 1 (add with overflow): result = B + A. The new T is 1 only when A and B have the same sign bit (bit 31) and the sign of the result differs from the sign of B. Otherwise the new T is 0.
- R5: Code 3 (subtract with overflow): result = B - A. The new T is 1 only when A and B have different sign bits and the sign of the result differs from the sign of B. Otherwise the new T is 0.
- R6: Code 5 (rotate left through T): result = {B[30:0], T}, and the new T is B[31].
- R7: Code 6 (rotate right through T): result = {T, B[31:1]}, and the new T is B[0].
- R8: Code 7 (pass): result = B, and the new T equals the incoming T. A has no effect on either output.
- R9: The flag register resets asynchronously to 0. At a rising clock edge it loads the new T when valid is 1, and it holds its value when valid is 0.
- R10: The write strobe output resets to 0. At each rising clock edge it takes the value that valid had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| src_a_i | input | 32 | Source operand A |
| dst_b_i | input | 32 | Destination operand B |
| t_i | input | 1 | Current T flag |
| valid_i | input | 1 | Load the new T into the flag register |
| result_o | output | 32 | Result word |
| t_next_o | output | 1 | New T value, combinational |
| t_q_o | output | 1 | Registered T flag |
| t_we_o | output | 1 | High in the cycle after the flag register was loaded |

## Verification
The hardest cases to reach are at the carry and borrow boundaries. In these cases the first step of the operation produces no carry or borrow, and only the extra T bit pushes the value across the 32-bit limit. Examples are B + A = 0xFFFFFFFF with T = 1, and B - A = 0 with T = 1. The overflow flags have a similar problem: they flip only at the exact signed limits 0x7FFFFFFF and 0x80000000. Random operands almost never land on these points. The bench therefore sweeps every code and both T values over a grid of operands built from 0, 1, all-ones, all-ones-minus-one, and the two signed limits, where many pairs land exactly on these boundaries. An LFSR adds scattered operand pairs. Each result is compared with a model that computes the flags arithmetically, using 64-bit sums in place of bit logic.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADDC  = 3'd0,
    OP_ADDV  = 3'd1,
    OP_SUBC  = 3'd2,
    OP_SUBV  = 3'd3,
    OP_NEGC  = 3'd4,
    OP_ROTL  = 3'd5,
    OP_ROTR  = 3'd6,
    OP_PASS  = 3'd7
  } op_e;
endpackage

// File: rtl/flag_alu_carry.sv
// Add or subtract with a one-bit carry/borrow, done in WIDTH+1 bits
module flag_alu_carry #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int EW = WIDTH + 1;
  logic [EW-1:0] ext_a, ext_b, ext_c, ext_r;

  assign ext_a = {1'b0, a_i};
  assign ext_b = {1'b0, b_i};
  assign ext_c = {{WIDTH{1'b0}}, cin_i};
  // the top bit is the carry, or the borrow when subtracting
  assign ext_r = sub_i ? (ext_b - ext_a - ext_c) : (ext_b + ext_a + ext_c);
  assign res_o  = ext_r[WIDTH-1:0];
  assign cout_o = ext_r[WIDTH];
endmodule

// File: rtl/flag_alu_ovf.sv
// Add or subtract with a signed-overflow flag
module flag_alu_ovf #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;
  logic sign_diff, res_flip;

  assign res_o     = sub_i ? (b_i - a_i) : (b_i + a_i);
  assign sign_diff = a_i[MSB] ^ b_i[MSB];
  assign res_flip  = res_o[MSB] ^ b_i[MSB];
  assign ovf_o     = res_flip & (sub_i ? sign_diff : ~sign_diff);
endmodule

// File: rtl/flag_alu_rot.sv
// Rotate one place through the flag bit, in either direction
module flag_alu_rot #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             t_i,
  input  logic             right_i,
  output logic [WIDTH-1:0] res_o,
  output logic             t_o
);
  logic [WIDTH-1:0] rot_l, rot_r;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign rot_l[i] = t_i;
    end else begin : g_lmid
      assign rot_l[i] = b_i[i-1];
    end
    if (i == WIDTH - 1) begin : g_hi
      assign rot_r[i] = t_i;
    end else begin : g_rmid
      assign rot_r[i] = b_i[i+1];
    end
  end

  assign res_o = right_i ? rot_r : rot_l;
  assign t_o   = right_i ? b_i[0] : b_i[WIDTH-1];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] dst_b_i,
  input  logic             t_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] result_o,
  output logic             t_next_o,
  output logic             t_q_o,
  output logic             t_we_o
);
  op_e              op;
  logic [WIDTH-1:0] cy_b, cy_res, ov_res, rt_res;
  logic             cy_sub, cy_out, ov_sub, ov_flag, rt_right, rt_t;

  assign op = op_e'(op_i);

  // negate reuses the borrow chain with B forced to zero
  assign cy_b   = (op == OP_NEGC) ? '0 : dst_b_i;
  assign cy_sub = (op == OP_SUBC) || (op == OP_NEGC);
  assign ov_sub = (op == OP_SUBV);
  assign rt_right = (op == OP_ROTR);

  flag_alu_carry #(.WIDTH(WIDTH)) u_carry (
    .a_i   (src_a_i),
    .b_i   (cy_b),
    .cin_i (t_i),
    .sub_i (cy_sub),
    .res_o (cy_res),
    .cout_o(cy_out)
  );

  flag_alu_ovf #(.WIDTH(WIDTH)) u_ovf (
    .a_i  (src_a_i),
    .b_i  (dst_b_i),
    .sub_i(ov_sub),
    .res_o(ov_res),
    .ovf_o(ov_flag)
  );

  flag_alu_rot #(.WIDTH(WIDTH)) u_rot (
    .b_i    (dst_b_i),
    .t_i    (t_i),
    .right_i(rt_right),
    .res_o  (rt_res),
    .t_o    (rt_t)
  );

  always_comb begin
    unique case (op)
      OP_ADDC, OP_SUBC, OP_NEGC: begin
        result_o = cy_res;
        t_next_o = cy_out;
      end
      OP_ADDV, OP_SUBV: begin
        result_o = ov_res;
        t_next_o = ov_flag;
      end
      OP_ROTL, OP_ROTR: begin
        result_o = rt_res;
        t_next_o = rt_t;
      end
      default: begin
        result_o = dst_b_i;
        t_next_o = t_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q_o  <= 1'b0;
      t_we_o <= 1'b0;
    end else begin
      t_we_o <= valid_i;
      if (valid_i) t_q_o <= t_next_o;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] src_a_i,
  input logic [WIDTH-1:0] dst_b_i,
  input logic             t_i,
  input logic             valid_i,
  input logic [WIDTH-1:0] result_o,
  input logic             t_next_o,
  input logic             t_q_o,
  input logic             t_we_o
);
  localparam int MSB = WIDTH - 1;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(t_q_o));

  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (t_q_o == $past(t_next_o)));

  a_r10_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (t_we_o == $past(valid_i)));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && (src_a_i[MSB] != dst_b_i[MSB])) |-> !t_next_o);

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && (src_a_i[MSB] == dst_b_i[MSB])) |-> !t_next_o);

  a_r6_rotl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |-> (result_o[0] == t_i && t_next_o == dst_b_i[MSB]));

  a_r7_rotr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6) |-> (result_o[MSB] == t_i && t_next_o == dst_b_i[0]));

  a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> (result_o == dst_b_i && t_next_o == t_i));
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .src_a_i (src_a_i),
  .dst_b_i (dst_b_i),
  .t_i     (t_i),
  .valid_i (valid_i),
  .result_o(result_o),
  .t_next_o(t_next_o),
  .t_q_o   (t_q_o),
  .t_we_o  (t_we_o)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [31:0] src_a_i = '0;
  logic [31:0] dst_b_i = '0;
  logic        t_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] result_o;
  logic        t_next_o, t_q_o, t_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  flag_alu u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // arithmetic reference model
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic t, output logic [31:0] r, output logic nt);
    logic [31:0] s1;
    longint sv;
    case (op)
      0: begin s1 = b + a; r = s1 + {31'd0, t}; nt = (s1 < b) || (r < s1); end
      2: begin s1 = b - a; r = s1 - {31'd0, t}; nt = (s1 > b) || (r > s1); end
      4: begin s1 = 32'd0 - a; r = s1 - {31'd0, t}; nt = (s1 != 0) || (r > s1); end
      1: begin
        r = b + a;
        sv = longint'($signed(b)) + longint'($signed(a));
        nt = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      3: begin
        r = b - a;
        sv = longint'($signed(b)) - longint'($signed(a));
        nt = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      5: begin r = (b << 1) | {31'd0, t}; nt = b[31]; end
      6: begin r = (b >> 1) | {t, 31'd0}; nt = b[0]; end
      default: begin r = b; nt = t; end
    endcase
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1"; 1: return "R4"; 2: return "R2"; 3: return "R5";
      4: return "R3"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b, input logic t);
    logic [31:0] er;
    logic en;
    op_i = op[2:0]; src_a_i = a; dst_b_i = b; t_i = t;
    #1;
    model(op, a, b, t, er, en);
    check(result_o === er, req_of(op), "result", result_o, er);
    check(t_next_o === en, req_of(op), "t_next", {31'd0, t_next_o}, {31'd0, en});
  endtask

  logic [31:0] grid [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                            32'hffffffff, 32'hfffffffe, 32'h80000001, 32'h55555555};

  initial begin
    logic [31:0] lfsr;
    #1;
    // reset state, R9 and R10
    check(t_q_o === 1'b0, "R9", "reset t_q", {31'd0, t_q_o}, 32'd0);
    check(t_we_o === 1'b0, "R10", "reset t_we", {31'd0, t_we_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // grid sweep over all codes, both T values: R1..R8
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int t = 0; t < 2; t++)
            apply(op, grid[i], grid[j], t[0]);

    // carry boundary reached only through T: R1, R2, R3
    apply(0, 32'hfffffff0, 32'h0000000f, 1'b1);
    apply(2, 32'h12345678, 32'h12345678, 1'b1);
    apply(4, 32'h0, 32'h0, 1'b1);
    apply(4, 32'h0, 32'hdeadbeef, 1'b0);

    // pass ignores A: R8
    apply(7, 32'hffffffff, 32'h0badf00d, 1'b1);
    apply(7, 32'h0, 32'h0badf00d, 1'b0);

    // scattered operands
    lfsr = 32'hace1_2468;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr;
      apply(k % 8, a, b, lfsr[3]);
    end

    // register behaviour: R9, R10
    @(negedge clk_i);
    op_i = 3'd0; src_a_i = 32'hffffffff; dst_b_i = 32'h1; t_i = 1'b0; valid_i = 1'b1;
    @(posedge clk_i); #1;
    check(t_q_o === 1'b1, "R9", "load 1", {31'd0, t_q_o}, 32'd1);
    check(t_we_o === 1'b1, "R10", "strobe after load", {31'd0, t_we_o}, 32'd1);
    @(negedge clk_i);
    src_a_i = 32'h1; dst_b_i = 32'h1; valid_i = 1'b0;
    @(posedge clk_i); #1;
    check(t_q_o === 1'b1, "R9", "hold without valid", {31'd0, t_q_o}, 32'd1);
    check(t_we_o === 1'b0, "R10", "strobe low", {31'd0, t_we_o}, 32'd0);
    @(negedge clk_i);
    valid_i = 1'b1;
    @(posedge clk_i); #1;
    check(t_q_o === 1'b0, "R9", "load 0", {31'd0, t_q_o}, 32'd0);
    @(negedge clk_i);
    op_i = 3'd5; dst_b_i = 32'h80000000;
    @(posedge clk_i); #1;
    check(t_q_o === 1'b1, "R9", "load from rotate", {31'd0, t_q_o}, 32'd1);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(t_q_o === 1'b0, "R9", "async reset", {31'd0, t_q_o}, 32'd0);
    check(t_we_o === 1'b0, "R10", "async reset strobe", {31'd0, t_we_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule